// File: doc/BRIEF.md
# Two-Wire JTAG Target Bridge

This block sits on the target side of a two-pin debug link and turns it back into the signals of a conventional four-wire test access port. The host drives a test clock and shares one bidirectional data pin with the target. The bridge runs on the chip's own system clock and oversamples both pins through a synchronizer. Control messages travel out of band as escapes: the host toggles the data pin several times while the test clock is held high, and the bridge counts those toggles. A long escape resets the internal TAP and takes the link offline. A shorter escape opens a twelve-bit activation packet. Only one specific packet value brings the link online.

Once online, every logical JTAG bit takes three test-clock periods. In the first period the host sends the inverted TDI value. In the second it sends TMS. In the third the bridge drives the TAP's TDO onto the shared pin and gives the internal TAP one clock, as a single system-clock enable pulse. The bridge has five states:

- ST_OFFLINE: idle after reset or after a reset escape.
- ST_ACTIVATE: collecting the packet.
- ST_NTDI, ST_TMS and ST_TDO: the three online phases.

The transitions are:

- any state to ST_OFFLINE on a reset escape;
- any state to ST_ACTIVATE on a selection escape;
- ST_ACTIVATE to ST_NTDI on a matching packet, or to ST_OFFLINE on any other packet;
- ST_NTDI to ST_TMS, ST_TMS to ST_TDO, and ST_TDO back to ST_NTDI, each on a test-clock rise.

Top module: `twowire_jtag_bridge`

## Requirements
- R1: After reset, tmsc_oe, tap_tck_en, tap_trst, tap_tms and tap_tdi are all 0, and the bridge is offline.
- R2: Eight or more data-pin edges while tck_i is high form a reset escape. At the next tck_i fall the bridge gives a one-cycle tap_trst pulse, releases the pin and goes offline.
- R3: Six or seven data-pin edges while tck_i is high form a selection escape. The next twelve tck_i rises then sample the activation packet.
- R4: Fewer than six edges while tck_i is high are ignored. The edge count restarts at every tck_i rise, so online bit decoding carries on unchanged.
- R5: Packet bits arrive in word order bit 0 first, filling word bits 0 to 11. Word bits 3:0 form the mode field, 7:4 the extension field and 11:8 the check field. A word of 12'h08C (mode 4'b1100, extension 4'b1000, check 4'b0000) brings the bridge online at the twelfth rise.
- R6: Any other packet value leaves the bridge offline.
- R7: Online, the pin value at the first-period rise is inverted into tap_tdi, and the value at the second-period rise goes into tap_tms. Both are stable when the TAP is clocked.
- R8: At the third-period rise, tap_tck_en pulses for exactly one system clock. There is one pulse per three periods and none in any other period.
- R9: tmsc_oe is high only from the tck_i fall that ends the second period to the fall that ends the third. While it is high, tmsc_o holds the tap_tdo value sampled at that first fall.
- R10: The phase restarts at the first period on entry to online mode and after any escape.
- R11: While offline, host periods produce no tap_tck_en pulse and tmsc_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Test clock from the host |
| tmsc_i | input | 1 | Level seen on the shared data pin |
| tmsc_o | output | 1 | Value the bridge drives on the shared pin |
| tmsc_oe | output | 1 | Output enable for the shared pin |
| tap_tdo | input | 1 | TDO from the internal TAP |
| tap_tck_en | output | 1 | One-cycle clock enable for the internal TAP |
| tap_tms | output | 1 | Recovered TMS |
| tap_tdi | output | 1 | Recovered TDI |
| tap_trst | output | 1 | One-cycle TAP reset pulse |

## Verification
All four TMS/TDI combinations are sent with alternating TDO values. This shows whether the inversion is applied to the first period only and whether the two sampled periods are ever swapped.

Escapes of four, five, six, seven and eight edges probe both count thresholds, including the odd-count cases. Packets that are wrong in only one field show that every field is compared.

A bit cut off after its first period and followed by a new activation shows whether the phase restarts. Periods sent while offline, before activation and after a reset escape, show that the TAP is never clocked and the pin never driven in that mode.

// File: rtl/tw_pkg.sv
package tw_pkg;

    typedef enum logic [2:0] {
        ST_OFFLINE,
        ST_ACTIVATE,
        ST_NTDI,
        ST_TMS,
        ST_TDO
    } tw_state_e;

    localparam int FIELD_W    = 4;
    localparam int FIELDS     = 3;
    localparam int PKT_W      = FIELD_W * FIELDS;

    // field order in the packet word: mode (lowest), extension, check
    localparam logic [FIELD_W-1:0] MODE_CODE = 4'b1100;
    localparam logic [FIELD_W-1:0] EXT_CODE  = 4'b1000;
    localparam logic [FIELD_W-1:0] CHK_CODE  = 4'b0000;
    localparam logic [PKT_W-1:0]   PKT_CODE  = {CHK_CODE, EXT_CODE, MODE_CODE};

    localparam int SEL_EDGES  = 6;
    localparam int RST_EDGES  = 8;

endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_i,
    input  logic tmsc_i,
    output logic tck_lvl,
    output logic tck_rise,
    output logic tck_fall,
    output logic tmsc_lvl,
    output logic tmsc_edge
);

    logic [STAGES-1:0] tck_sh;
    logic [STAGES-1:0] tmsc_sh;
    logic              tck_prev;
    logic              tmsc_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_sh    <= '0;
            tmsc_sh   <= '0;
            tck_prev  <= 1'b0;
            tmsc_prev <= 1'b0;
        end else begin
            tck_sh[0]  <= tck_i;
            tmsc_sh[0] <= tmsc_i;
            for (int i = 1; i < STAGES; i++) begin
                tck_sh[i]  <= tck_sh[i-1];
                tmsc_sh[i] <= tmsc_sh[i-1];
            end
            tck_prev  <= tck_sh[STAGES-1];
            tmsc_prev <= tmsc_sh[STAGES-1];
        end
    end

    assign tck_lvl   = tck_sh[STAGES-1];
    assign tmsc_lvl  = tmsc_sh[STAGES-1];
    assign tck_rise  = tck_lvl & ~tck_prev;
    assign tck_fall  = ~tck_lvl & tck_prev;
    assign tmsc_edge = tmsc_lvl ^ tmsc_prev;

endmodule

// File: rtl/tw_escape_det.sv
module tw_escape_det #(
    parameter int CNT_W     = 4,
    parameter int SEL_EDGES = 6,
    parameter int RST_EDGES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_lvl,
    input  logic tck_rise,
    input  logic tck_fall,
    input  logic tmsc_edge,
    output logic esc_select,
    output logic esc_reset
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SEL_LIM = CNT_W'(SEL_EDGES);
    localparam logic [CNT_W-1:0] RST_LIM = CNT_W'(RST_EDGES);

    logic [CNT_W-1:0] edge_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (tck_rise) begin
            edge_cnt_q <= '0;
        end else if (tck_lvl && tmsc_edge && (edge_cnt_q != CNT_MAX)) begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    // judged once per high phase, at the falling test clock
    assign esc_reset  = tck_fall && (edge_cnt_q >= RST_LIM);
    assign esc_select = tck_fall && (edge_cnt_q >= SEL_LIM) && (edge_cnt_q < RST_LIM);

endmodule

// File: rtl/tw_act_decoder.sv
module tw_act_decoder #(
    parameter int FIELD_W = 4,
    parameter int FIELDS  = 3,
    parameter logic [FIELD_W*FIELDS-1:0] EXPECT = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sample,
    input  logic bit_in,
    output logic done,
    output logic match
);

    localparam int TOTAL = FIELD_W * FIELDS;
    localparam int IDX_W = $clog2(TOTAL);

    logic [TOTAL-1:0]  word_q;
    logic [TOTAL-1:0]  word_nx;
    logic [IDX_W-1:0]  idx_q;
    logic [FIELDS-1:0] fld_ok;

    always_comb begin
        word_nx = word_q;
        for (int i = 0; i < TOTAL; i++) begin
            if (idx_q == IDX_W'(i)) begin
                word_nx[i] = bit_in;
            end
        end
    end

    assign done = sample && (idx_q == IDX_W'(TOTAL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (sample) begin
            word_q <= word_nx;
            idx_q  <= done ? '0 : idx_q + 1'b1;
        end
    end

    genvar f;
    for (f = 0; f < FIELDS; f++) begin : g_field
        assign fld_ok[f] = (word_nx[f*FIELD_W +: FIELD_W] == EXPECT[f*FIELD_W +: FIELD_W]);
    end

    assign match = &fld_ok;

endmodule

// File: rtl/twowire_jtag_bridge.sv
module twowire_jtag_bridge
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ESC_CNT_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tck_i,
    input  logic tmsc_i,
    output logic tmsc_o,
    output logic tmsc_oe,
    input  logic tap_tdo,
    output logic tap_tck_en,
    output logic tap_tms,
    output logic tap_tdi,
    output logic tap_trst
);

    logic      tck_lvl, tck_rise, tck_fall, tmsc_lvl, tmsc_edge;
    logic      esc_select, esc_reset;
    logic      act_done, act_match, act_sample;
    tw_state_e state_q, state_d;

    tw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tck_i     (tck_i),
        .tmsc_i    (tmsc_i),
        .tck_lvl   (tck_lvl),
        .tck_rise  (tck_rise),
        .tck_fall  (tck_fall),
        .tmsc_lvl  (tmsc_lvl),
        .tmsc_edge (tmsc_edge)
    );

    tw_escape_det #(
        .CNT_W     (ESC_CNT_W),
        .SEL_EDGES (SEL_EDGES),
        .RST_EDGES (RST_EDGES)
    ) u_esc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tck_lvl    (tck_lvl),
        .tck_rise   (tck_rise),
        .tck_fall   (tck_fall),
        .tmsc_edge  (tmsc_edge),
        .esc_select (esc_select),
        .esc_reset  (esc_reset)
    );

    assign act_sample = tck_rise && (state_q == ST_ACTIVATE);

    tw_act_decoder #(
        .FIELD_W (FIELD_W),
        .FIELDS  (FIELDS),
        .EXPECT  (PKT_CODE)
    ) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (esc_select),
        .sample (act_sample),
        .bit_in (tmsc_lvl),
        .done   (act_done),
        .match  (act_match)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFFLINE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: phases move on test-clock rises, escapes on falls
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFFLINE:  state_d = ST_OFFLINE;
            ST_ACTIVATE: if (act_done) state_d = act_match ? ST_NTDI : ST_OFFLINE;
            ST_NTDI:     if (tck_rise) state_d = ST_TMS;
            ST_TMS:      if (tck_rise) state_d = ST_TDO;
            ST_TDO:      if (tck_rise) state_d = ST_NTDI;
            default:     state_d = ST_OFFLINE;
        endcase
        if (esc_reset) begin
            state_d = ST_OFFLINE;
        end else if (esc_select) begin
            state_d = ST_ACTIVATE;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_tck_en <= 1'b0;
            tap_trst   <= 1'b0;
            tap_tdi    <= 1'b0;
            tap_tms    <= 1'b0;
            tmsc_oe    <= 1'b0;
            tmsc_o     <= 1'b0;
        end else begin
            tap_tck_en <= tck_rise && (state_q == ST_TDO);
            tap_trst   <= esc_reset;
            if (tck_rise && (state_q == ST_NTDI)) begin
                tap_tdi <= ~tmsc_lvl;
            end
            if (tck_rise && (state_q == ST_TMS)) begin
                tap_tms <= tmsc_lvl;
            end
            if (tck_fall) begin
                tmsc_oe <= (state_q == ST_TDO) && !esc_reset && !esc_select;
                if (state_q == ST_TDO) begin
                    tmsc_o <= tap_tdo;
                end
            end
        end
    end

endmodule

// File: rtl/tw_bridge_chk.sv
module tw_bridge_chk
    import tw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tap_tck_en,
    input logic      tap_trst,
    input logic      tmsc_oe,
    input logic      tmsc_o,
    input logic      tap_tms,
    input logic      tap_tdi,
    input tw_state_e state_q
);

    // R8
    tck_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tck_en |=> !tap_tck_en);

    // R8
    tck_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tck_en |-> (state_q == ST_NTDI));

    // R2
    trst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_trst |=> !tap_trst);

    // R2
    trst_offline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_trst |-> (!tmsc_oe && state_q == ST_OFFLINE));

    // R9
    tdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmsc_oe && $past(tmsc_oe)) |-> $stable(tmsc_o));

    // R9
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmsc_oe |-> (state_q == ST_TDO || state_q == ST_NTDI));

    // R7
    tap_inputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_tck_en |-> ($stable(tap_tms) && $stable(tap_tdi)));

endmodule

bind twowire_jtag_bridge tw_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_tck_en (tap_tck_en),
    .tap_trst   (tap_trst),
    .tmsc_oe    (tmsc_oe),
    .tmsc_o     (tmsc_o),
    .tap_tms    (tap_tms),
    .tap_tdi    (tap_tdi),
    .state_q    (state_q)
);

// File: tb/twowire_jtag_bridge_test.sv
`timescale 1ns/1ps
module twowire_jtag_bridge_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck = 1'b0;
    logic host_pin = 1'b0;
    logic tap_tdo = 1'b0;
    logic tmsc_o, tmsc_oe, tap_tck_en, tap_tms, tap_tdi, tap_trst;
    logic tmsc_pin;

    assign tmsc_pin = tmsc_oe ? tmsc_o : host_pin;

    always #2 clk = ~clk;

    twowire_jtag_bridge uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tck_i      (tck),
        .tmsc_i     (tmsc_pin),
        .tmsc_o     (tmsc_o),
        .tmsc_oe    (tmsc_oe),
        .tap_tdo    (tap_tdo),
        .tap_tck_en (tap_tck_en),
        .tap_tms    (tap_tms),
        .tap_tdi    (tap_tdi),
        .tap_trst   (tap_trst)
    );

    int vectors = 0;
    int errors  = 0;
    int pulses  = 0;
    int trsts   = 0;
    logic [1:0] exp_q[$];   // {tms, tdi}

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every TAP clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (tap_trst) trsts++;
            if (tap_tck_en) begin
                pulses++;
                vectors++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11: actual unexpected TAP clock expected none");
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    if ({tap_tms, tap_tdi} !== e) begin
                        errors++;
                        $display("FAIL R7: actual %b expected %b", {tap_tms, tap_tdi}, e);
                    end
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one host period: pin set mid-low, rise, optional edges while high
    task automatic period(input logic v, input int edges);
        tck = 1'b0;
        wait_clk(4);
        host_pin = v;
        wait_clk(4);
        tck = 1'b1;
        wait_clk(8);
        for (int k = 0; k < edges; k++) begin
            host_pin = ~host_pin;
            wait_clk(4);
        end
    endtask

    task automatic send_bit(input logic tdi, input logic tms, input logic tdo,
                            input logic online, input int glitch);
        if (online) exp_q.push_back({tms, tdi});
        tap_tdo = tdo;
        period(~tdi, glitch);
        chk("R9 oe low in first period", tmsc_oe, 1'b0);
        period(tms, 0);
        chk("R9 oe low in second period", tmsc_oe, 1'b0);
        tck = 1'b0;
        wait_clk(8);
        chk("R9 oe in third period", tmsc_oe, online);
        if (online) chk("R9 tdo on pin", tmsc_pin, tdo);
        tck = 1'b1;
        wait_clk(8);
    endtask

    task automatic escape(input int n);
        tck = 1'b0;
        wait_clk(4);
        host_pin = 1'b0;
        wait_clk(4);
        tck = 1'b1;
        wait_clk(8);
        for (int k = 0; k < n; k++) begin
            host_pin = ~host_pin;
            wait_clk(4);
        end
        tck = 1'b0;
        wait_clk(8);
    endtask

    task automatic packet(input logic [11:0] w);
        for (int i = 0; i < 12; i++) period(w[i], 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int p0;
        int t0;
        wait_clk(5);
        // R1 reset state
        chk("R1 tmsc_oe", tmsc_oe, 0);
        chk("R1 tap_tck_en", tap_tck_en, 0);
        chk("R1 tap_trst", tap_trst, 0);
        chk("R1 tap_tms/tdi", {tap_tms, tap_tdi}, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 R11 offline before any activation
        p0 = pulses;
        send_bit(1, 0, 1, 0, 0);
        send_bit(0, 1, 0, 0, 0);
        chk("R11 no clocks offline", pulses - p0, 0);

        // R2 reset escape
        t0 = trsts;
        escape(8);
        chk("R2 trst pulse", trsts - t0, 1);
        chk("R2 pin released", tmsc_oe, 0);

        // R3 R5 select + matching packet 12'h08C
        escape(6);
        packet(12'h08C);
        p0 = pulses;
        send_bit(0, 0, 1, 1, 0);
        send_bit(1, 0, 0, 1, 0);
        send_bit(0, 1, 1, 1, 0);
        send_bit(1, 1, 0, 1, 0);
        chk("R8 one clock per bit", pulses - p0, 4);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        // R4 five and four edges while high are ignored
        p0 = pulses;
        send_bit(1, 0, 1, 1, 5);
        send_bit(0, 1, 0, 1, 4);
        chk("R4 short escapes ignored", pulses - p0, 2);

        // R10 partial bit then seven-edge select escape (R3)
        period(1'b0, 0);
        escape(7);
        packet(12'h08C);
        p0 = pulses;
        send_bit(1, 1, 1, 1, 0);
        chk("R10 phase restart", pulses - p0, 1);
        chk("R3 seven edges select", exp_q.size(), 0);

        // R6 wrong mode field
        escape(6);
        packet(12'h08D);
        p0 = pulses;
        send_bit(1, 0, 0, 0, 0);
        chk("R6 bad mode field", pulses - p0, 0);
        // R6 wrong extension field
        escape(6);
        packet(12'h00C);
        send_bit(0, 1, 1, 0, 0);
        chk("R6 bad extension field", pulses - p0, 0);
        // R6 wrong check field
        escape(6);
        packet(12'h18C);
        send_bit(1, 1, 0, 0, 0);
        chk("R6 bad check field", pulses - p0, 0);

        // R2 R11 reset escape while online
        escape(6);
        packet(12'h08C);
        send_bit(0, 1, 0, 1, 0);
        t0 = trsts;
        p0 = pulses;
        escape(8);
        chk("R2 trst while online", trsts - t0, 1);
        send_bit(1, 0, 1, 0, 0);
        chk("R11 offline after reset escape", pulses - p0, 0);
        chk("R7 scoreboard drained", exp_q.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule